// File: doc/BRIEF.md
# Floppy Controller Command Sequencer

This block is the host-facing command engine of a floppy disk controller. A processor talks to it through eight byte-wide register offsets with separate read and write strobes. The block runs the three phases of a controller command. It collects the opcode and parameter bytes, it steps the head of one drive toward a target cylinder, and it hands back result bytes. The host paces every transfer by polling the main status byte. That byte shows whether the controller is ready, which way the next FIFO byte moves, and whether a command is in progress.

Three positioning commands are supported: an absolute seek, a relative seek toward higher cylinders, and a relative seek toward lower cylinders. A sense-interrupt command reads and acknowledges the completion status. The drive side gets a one-cycle step pulse with a direction level, and it reports whether a diskette is inserted. A disk-changed latch, readable in bit 7 of the digital input offset, records diskette removal. Only a real head step with media present clears it.

Top module: `fdc_cmd_seq`

## Requirements
- R1: After reset the main status byte (offset 4) reads 0x80, irq is 0, bit 7 of offset 7 reads 1 and the present cylinder is 0.
- R2: The main status byte uses bit 7 for ready, bit 6 for direction (1 = controller to host) and bit 4 for busy, with bit 5 always 0. It reads 0x80 when idle, 0x90 while parameters are collected, 0x10 while the head moves and 0xD0 while result bytes are pending.
- R3: Opcode 0x0F (seek) takes two parameter bytes at offset 5: a head/drive byte (bits 2:0 kept) and a target cylinder. irq stays 0 until the seek has finished. The head moves one cylinder per step pulse, and pulses are STEP_CYC cycles apart. step_dir is 1 when the cylinder increases.
- R4: When a seek finishes, irq rises and the stored status byte becomes 0x20 OR'd with the head/drive bits 2:0.
- R5: Opcode 0xCF adds its cylinder parameter to the present cylinder, saturating at MAX_CYL. Opcode 0x8F subtracts it, saturating at 0. An absolute target above MAX_CYL is limited to MAX_CYL.
- R6: Opcode 0x08 with irq pending returns the status byte, then the present cylinder. irq falls when the second byte is read.
- R7: Opcode 0x08 with no irq pending returns the single byte 0x80, and the block goes back to idle.
- R8: Any other opcode returns the single byte 0x80, and the block goes back to idle.
- R9: Bit 7 of offset 7 is set by reset and by media removal. Reading it does not clear it. Only a step pulse while media_present is 1 clears it.
- R10: A FIFO write while the block is moving the head or returning results is ignored. So are writes to any offset other than 5. A FIFO read outside the result phase returns 0 and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register offset |
| rd_stb | input | 1 | One-cycle read strobe |
| wr_stb | input | 1 | One-cycle write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current offset |
| irq | output | 1 | Completion interrupt |
| step | output | 1 | One-cycle head step pulse |
| step_dir | output | 1 | Step direction, 1 = toward higher cylinders |
| media_present | input | 1 | Diskette inserted |

## Verification
The hardest state to reach from the ports is the disk-changed latch being cleared. That needs media present, a seek that moves the head, and a removal that follows. Seeks to the current cylinder and seeks without media must leave the latch alone. The bench first seeks with no diskette and then seeks in place with a diskette. Only after that does it command a real step, and it ends by withdrawing media. A second hard case is a command byte arriving while the head is still moving. The bench issues it right after the last parameter of a long seek, then checks that the cylinder reported later is unaffected.

// File: rtl/fdc_seq_pkg.sv
package fdc_seq_pkg;

  typedef enum logic [1:0] {PH_IDLE, PH_PARAM, PH_EXEC, PH_RESULT} phase_e;

  localparam logic [7:0] OP_SEEK      = 8'h0F;
  localparam logic [7:0] OP_SEEK_UP   = 8'hCF;
  localparam logic [7:0] OP_SEEK_DN   = 8'h8F;
  localparam logic [7:0] OP_SENSE     = 8'h08;
  localparam logic [7:0] RES_INVALID  = 8'h80;
  localparam logic [7:0] ST0_SEEK_END = 8'h20;

  localparam logic [2:0] OFS_MSR  = 3'd4;
  localparam logic [2:0] OFS_FIFO = 3'd5;
  localparam logic [2:0] OFS_DIN  = 3'd7;

  function automatic logic is_seek_op(logic [7:0] op);
    return (op == OP_SEEK) || (op == OP_SEEK_UP) || (op == OP_SEEK_DN);
  endfunction

  // status byte: ready, direction, non-DMA (unused), busy
  function automatic logic [7:0] msr_code(phase_e ph);
    case (ph)
      PH_IDLE:   return 8'h80;
      PH_PARAM:  return 8'h90;
      PH_EXEC:   return 8'h10;
      default:   return 8'hD0;
    endcase
  endfunction

  // cylinder the head must reach, saturated to [0, maxc]
  function automatic logic [7:0] seek_target(logic [7:0] op, logic [7:0] cur,
                                             logic [7:0] arg, logic [7:0] maxc);
    logic [8:0] sum;
    sum = {1'b0, cur} + {1'b0, arg};
    case (op)
      OP_SEEK_UP: return (sum > {1'b0, maxc}) ? maxc : sum[7:0];
      OP_SEEK_DN: return (arg > cur) ? 8'd0 : cur - arg;
      default:    return (arg > maxc) ? maxc : arg;
    endcase
  endfunction

endpackage

// File: rtl/fdc_step_engine.sv
module fdc_step_engine #(
  parameter int STEP_CYC = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] target,
  output logic [7:0] pcn,
  output logic       done,
  output logic       step_evt,
  output logic       step,
  output logic       step_dir
);
  localparam int TW = (STEP_CYC > 2) ? $clog2(STEP_CYC) : 1;
  localparam logic [TW-1:0] RELOAD = TW'(STEP_CYC - 1);

  logic          active;
  logic [TW-1:0] tmr;
  logic [7:0]    tgt;

  assign done     = active && (tmr == '0) && (pcn == tgt);
  assign step_evt = active && (tmr == '0) && (pcn != tgt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      tmr      <= '0;
      tgt      <= '0;
      pcn      <= '0;
      step     <= 1'b0;
      step_dir <= 1'b0;
    end else begin
      step <= step_evt;
      if (start) begin
        active <= 1'b1;
        tgt    <= target;
        tmr    <= RELOAD;
      end else if (active) begin
        if (tmr != '0) begin
          tmr <= tmr - 1'b1;
        end else if (pcn == tgt) begin
          active <= 1'b0;
        end else begin
          pcn      <= (tgt > pcn) ? pcn + 8'd1 : pcn - 8'd1;
          step_dir <= (tgt > pcn);
          tmr      <= RELOAD;
        end
      end
    end
  end
endmodule

// File: rtl/fdc_media_latch.sv
module fdc_media_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic media_present,
  input  logic step_evt,
  output logic dskchg
);
  logic media_prev;
  logic removal;

  assign removal = media_prev && !media_present;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      media_prev <= 1'b0;
      dskchg     <= 1'b1;
    end else begin
      media_prev <= media_present;
      if (removal)
        dskchg <= 1'b1;
      else if (step_evt && media_present)
        dskchg <= 1'b0;
    end
  end
endmodule

// File: rtl/fdc_cmd_fsm.sv
module fdc_cmd_fsm
  import fdc_seq_pkg::*;
#(
  parameter int MAX_CYL = 79
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic [7:0] wdata,
  input  logic       res_rd,
  input  logic [7:0] pcn,
  input  logic       seek_done,
  output phase_e     phase,
  output logic       start,
  output logic [7:0] target,
  output logic       irq,
  output logic [7:0] res_byte
);
  localparam logic [7:0] MAXC = 8'(MAX_CYL);

  logic [7:0] op;
  logic       need_hd;
  logic [2:0] hd;
  logic [7:0] st0;
  logic [7:0] res0, res1;
  logic       res_two, res_idx;

  assign start    = (phase == PH_PARAM) && cmd_wr && !need_hd;
  assign target   = seek_target(op, pcn, wdata, MAXC);
  assign res_byte = res_idx ? res1 : res0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      op      <= '0;
      need_hd <= 1'b0;
      hd      <= '0;
      st0     <= '0;
      res0    <= '0;
      res1    <= '0;
      res_two <= 1'b0;
      res_idx <= 1'b0;
      irq     <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: if (cmd_wr) begin
          op      <= wdata;
          res_idx <= 1'b0;
          if (is_seek_op(wdata)) begin
            phase   <= PH_PARAM;
            need_hd <= 1'b1;
          end else if ((wdata == OP_SENSE) && irq) begin
            res0    <= st0;
            res1    <= pcn;
            res_two <= 1'b1;
            phase   <= PH_RESULT;
          end else begin
            res0    <= RES_INVALID;
            res_two <= 1'b0;
            phase   <= PH_RESULT;
          end
        end
        PH_PARAM: if (cmd_wr) begin
          if (need_hd) begin
            hd      <= wdata[2:0];
            need_hd <= 1'b0;
          end else begin
            phase <= PH_EXEC;
          end
        end
        PH_EXEC: if (seek_done) begin
          phase <= PH_IDLE;
          irq   <= 1'b1;
          st0   <= ST0_SEEK_END | {5'd0, hd};
        end
        default: if (res_rd) begin
          if (res_two && !res_idx) begin
            res_idx <= 1'b1;
          end else begin
            phase   <= PH_IDLE;
            res_idx <= 1'b0;
            if (res_two) irq <= 1'b0;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/fdc_cmd_seq.sv
module fdc_cmd_seq
  import fdc_seq_pkg::*;
#(
  parameter int MAX_CYL  = 79,
  parameter int STEP_CYC = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] addr,
  input  logic       rd_stb,
  input  logic       wr_stb,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq,
  output logic       step,
  output logic       step_dir,
  input  logic       media_present
);
  phase_e     phase;
  logic       cmd_wr, res_rd;
  logic       start, seek_done, step_evt, dskchg;
  logic [7:0] target, pcn, res_byte;

  // host events brought out as named wires
  assign cmd_wr = wr_stb && (addr == OFS_FIFO) &&
                  ((phase == PH_IDLE) || (phase == PH_PARAM));
  assign res_rd = rd_stb && (addr == OFS_FIFO) && (phase == PH_RESULT);

  fdc_cmd_fsm #(.MAX_CYL(MAX_CYL)) u_fsm (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .wdata(wdata),
    .res_rd(res_rd), .pcn(pcn), .seek_done(seek_done), .phase(phase),
    .start(start), .target(target), .irq(irq), .res_byte(res_byte)
  );

  fdc_step_engine #(.STEP_CYC(STEP_CYC)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start), .target(target), .pcn(pcn),
    .done(seek_done), .step_evt(step_evt), .step(step), .step_dir(step_dir)
  );

  fdc_media_latch u_media (
    .clk(clk), .rst_n(rst_n), .media_present(media_present),
    .step_evt(step_evt), .dskchg(dskchg)
  );

  always_comb begin
    case (addr)
      OFS_MSR:  rdata = msr_code(phase);
      OFS_FIFO: rdata = (phase == PH_RESULT) ? res_byte : 8'h00;
      OFS_DIN:  rdata = {dskchg, 7'd0};
      default:  rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/fdc_cmd_seq_chk.sv
module fdc_cmd_seq_chk #(
  parameter int MAX_CYL  = 79,
  parameter int STEP_CYC = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] addr,
  input logic       rd_stb,
  input logic       irq,
  input logic       media_present,
  input logic       dskchg,
  input logic       step_evt,
  input logic       seek_done,
  input logic [7:0] pcn
);
  AST_IRQ_RISES_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(seek_done)); // R4
  AST_IRQ_FALLS_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(rd_stb && addr == 3'd5)); // R6
  AST_DSKCHG_CLEAR_NEEDS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dskchg) |-> $past(step_evt && media_present)); // R9
  AST_PCN_MOVES_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pcn != $past(pcn)) |-> $past(step_evt)); // R3
  AST_STEP_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    (STEP_CYC > 1 && step_evt) |=> !step_evt); // R3
  AST_PCN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    32'(pcn) <= MAX_CYL); // R5
endmodule

bind fdc_cmd_seq fdc_cmd_seq_chk #(.MAX_CYL(MAX_CYL), .STEP_CYC(STEP_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rd_stb(rd_stb), .irq(irq),
  .media_present(media_present), .dskchg(dskchg), .step_evt(step_evt),
  .seek_done(seek_done), .pcn(pcn)
);

// File: tb/test_fdc_cmd_seq.sv
`timescale 1ns/1ps
module test_fdc_cmd_seq;
  localparam int MAXC = 15;
  localparam int SCYC = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       rd_stb = 1'b0, wr_stb = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq, step, step_dir;
  logic       media_present = 1'b0;

  int tests = 0, fails = 0;
  int step_cnt = 0;
  int last_dir = 0;
  int exp_pcn = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  fdc_cmd_seq #(.MAX_CYL(MAXC), .STEP_CYC(SCYC)) i_fdc_cmd_seq (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .wdata(wdata), .rdata(rdata), .irq(irq), .step(step),
    .step_dir(step_dir), .media_present(media_present)
  );

  always @(posedge clk) if (step) begin
    step_cnt = step_cnt + 1;
    last_dir = int'(step_dir);
  end

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output int v);
    @(negedge clk);
    addr = a; rd_stb = 1'b1;
    #1 v = int'(rdata);
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic wait_idle();
    int v;
    for (int k = 0; k < 500; k++) begin
      rd(3'd4, v);
      if (v == 8'h80) break;
    end
  endtask

  function automatic int clamp(int v);
    if (v < 0) return 0;
    if (v > MAXC) return MAXC;
    return v;
  endfunction

  // issue a positioning command and check motion and irq
  task automatic seek(logic [7:0] op, int hd, int arg, string req);
    int nt, v;
    case (op)
      8'hCF:   nt = clamp(exp_pcn + arg);
      8'h8F:   nt = clamp(exp_pcn - arg);
      default: nt = clamp(arg);
    endcase
    step_cnt = 0;
    wr(3'd5, op);
    wr(3'd5, 8'(hd));
    chk({req, " irq low after head byte"}, int'(irq), 0);
    wr(3'd5, 8'(arg));
    wait_idle();
    chk({req, " step count"}, step_cnt, (nt > exp_pcn) ? nt - exp_pcn : exp_pcn - nt);
    if (nt != exp_pcn) chk("R3 step_dir", last_dir, (nt > exp_pcn) ? 1 : 0);
    chk("R4 irq after seek", int'(irq), 1);
    exp_pcn = nt;
    wr(3'd5, 8'h08);
    rd(3'd5, v);
    chk("R4 R6 status byte", v, 8'h20 | (hd & 7));
    rd(3'd5, v);
    chk({req, " R6 cylinder"}, v, exp_pcn);
    chk("R6 irq cleared", int'(irq), 0);
    rd(3'd4, v);
    chk("R2 idle after sense", v, 8'h80);
  endtask

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(3'd4, v); chk("R1 status after reset", v, 8'h80);
    chk("R1 irq after reset", int'(irq), 0);
    rd(3'd7, v); chk("R1 R9 disk changed at reset", v & 8'h80, 8'h80);
    rd(3'd7, v); chk("R9 read does not clear", v & 8'h80, 8'h80);

    // R7: sense with nothing pending
    wr(3'd5, 8'h08);
    rd(3'd4, v); chk("R2 status in result", v, 8'hD0);
    rd(3'd5, v); chk("R7 invalid byte", v, 8'h80);
    rd(3'd4, v); chk("R7 back to idle", v, 8'h80);

    // R10: idle FIFO read and stray writes
    rd(3'd5, v); chk("R10 idle FIFO read", v, 0);
    wr(3'd4, 8'h0F); wr(3'd2, 8'h0C); wr(3'd0, 8'hFF);
    rd(3'd4, v); chk("R10 stray writes ignored", v, 8'h80);
    chk("R10 irq untouched", int'(irq), 0);

    // R2: phase codes
    wr(3'd5, 8'h0F);
    rd(3'd4, v); chk("R2 status in parameter phase", v, 8'h90);
    wr(3'd5, 8'h00);
    wr(3'd5, 8'd2);
    rd(3'd4, v); chk("R2 status while moving", v, 8'h10);
    wait_idle();
    exp_pcn = 2;
    wr(3'd5, 8'h08); rd(3'd5, v); rd(3'd5, v);
    chk("R3 cylinder after first seek", v, 2);

    // R9: steps without media keep flag
    seek(8'h0F, 0, 1, "R3");
    rd(3'd7, v); chk("R9 no media keeps flag", v & 8'h80, 8'h80);
    media_present = 1'b1;
    seek(8'h0F, 0, 1, "R3");
    rd(3'd7, v); chk("R9 in-place seek keeps flag", v & 8'h80, 8'h80);
    seek(8'h0F, 0, 0, "R3");
    rd(3'd7, v); chk("R9 step with media clears", v & 8'h80, 0);

    // absolute sweep, including targets above MAX_CYL
    for (int t = 0; t <= MAXC + 2; t++) seek(8'h0F, t % 8, t, "R3 R5 abs");
    // relative sweeps
    seek(8'h0F, 0, 0, "R5");
    for (int d = 0; d <= 6; d++) seek(8'hCF, d, d, "R5 up");
    for (int d = 0; d <= 7; d++) seek(8'h8F, d, d, "R5 down");
    seek(8'h0F, 1, 10, "R5");
    seek(8'hCF, 2, 200, "R5 up saturate");
    seek(8'h8F, 3, 250, "R5 down saturate");

    // R10: FIFO write during motion and during results
    wr(3'd5, 8'h0F); wr(3'd5, 8'h00); wr(3'd5, 8'd12);
    wr(3'd5, 8'h08);
    wr(3'd5, 8'h8F);
    wait_idle();
    exp_pcn = 12;
    wr(3'd5, 8'h08);
    wr(3'd5, 8'hCF);
    rd(3'd5, v); chk("R10 status byte kept", v, 8'h20);
    wr(3'd5, 8'h0F);
    rd(3'd5, v); chk("R10 cylinder unaffected by writes", v, 12);
    rd(3'd4, v); chk("R10 idle after result", v, 8'h80);

    // R8: every other opcode
    for (int op = 0; op < 256; op++) begin
      if (op == 8'h0F || op == 8'hCF || op == 8'h8F || op == 8'h08) continue;
      wr(3'd5, 8'(op));
      rd(3'd5, v); chk($sformatf("R8 opcode %0h result", op), v, 8'h80);
      rd(3'd4, v); chk("R8 back to idle", v, 8'h80);
    end

    // R9: removal sets flag, reads keep it
    media_present = 1'b0;
    repeat (2) @(negedge clk);
    rd(3'd7, v); chk("R9 removal sets flag", v & 8'h80, 8'h80);
    rd(3'd7, v); chk("R9 flag persists", v & 8'h80, 8'h80);

    done_flag = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule